// File: doc/BRIEF.md
# Transhybrid Echo Balance Filter

This block builds a digital replica of the echo that a telephone line reflects back into the codec, and subtracts it from the received signal. Every sample period (16 kHz) the host presents, for one line, a transmit-path sample and the matching received sample, together with a valid strobe. The transmit sample goes through an 8-tap FIR section. The FIR result then goes through a direct-form-I biquad. The biquad output is the echo estimate, and the block subtracts it from the received sample. The result leaves with an output-valid pulse a fixed two clock cycles after the strobe.

Several lines share one datapath. Each line has its own coefficient bank, loaded through a write port, and its own delay lines. A per-line disable input turns the cancellation off, so that loopback diagnostics see the received sample unchanged. Writing a coefficient or disabling a line empties that line's history, so no stale filter state survives a reconfiguration. All coefficients of a line should be loaded before the line is enabled. Until then, the bank holds zero after reset.

Top module: `echo_bal_filter`

## Requirements
- R1: After reset, `res_vld` is low and every coefficient of every line is zero, so an enabled line returns its received sample unchanged.
- R2: Each cycle with `smp_vld` high yields exactly one cycle of `res_vld` two clock edges later, with `res_line` equal to the strobed `smp_line`. `res_vld` is low in all other cycles.
- R3: The FIR output is f = sat16((sum over k=0..7 of h_k * x[n-k]) >>> 14), where x[n] is the current transmit sample and h_k is the coefficient at write index k (0 to 7). Coefficients are signed Q1.14.
- R4: The echo estimate is y = sat16((b0*f[n] + b1*f[n-1] + b2*f[n-2] - a1*y[n-1] - a2*y[n-2]) >>> 14). Write index 8 holds b0, 9 holds b1, 10 holds b2, 11 holds a1 and 12 holds a2.
- R5: For an enabled line, `res_smp` = sat16(`rx_smp` - y).
- R6: Each of f, y and the output clamps to the range -32768..32767 instead of wrapping. The shift is arithmetic, rounding toward minus infinity.
- R7: The coefficients and delay lines of one line are unaffected by samples or coefficient writes addressed to another line.
- R8: While `bal_off[l]` is 1, a sample for line l yields `res_smp` = `rx_smp`, and the line's delay lines are held at zero. After re-enabling, filtering restarts from empty history.
- R9: A coefficient write (index 0 to 12) to line l clears all of line l's delay lines.
- R10: A coefficient write with index 13, 14 or 15 changes no coefficient and clears no history.
- R11: Strobes on consecutive cycles, for the same or different lines, are all processed in order with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_line | input | LINE_W | Line index of the strobed sample |
| tx_smp | input | 16 | Signed transmit-path sample |
| rx_smp | input | 16 | Signed received sample |
| bal_off | input | NUM_LINES | Per-line cancellation disable |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_line | input | LINE_W | Line of the coefficient write |
| cfg_idx | input | 4 | Coefficient index (0-7 taps, 8-12 biquad) |
| cfg_data | input | 16 | Signed Q1.14 coefficient value |
| res_vld | output | 1 | Result valid pulse |
| res_line | output | LINE_W | Line of the result |
| res_smp | output | 16 | Echo-cancelled signed sample |

## Verification
The bench builds the block with NUM_LINES = 3. This gives a line index of two bits with one value unused, and a bank depth that is not a power of two. It also lets a third line sit idle while two others interleave, which exposes any leakage of coefficients or history between lines. Coefficient sets, samples and line order are drawn at random from a fixed seed. Directed cases cover impulse responses, clamping at both ends, disable and re-enable, clearing on write, and writes to the unused indices.

// File: rtl/ebf_pkg.sv
package ebf_pkg;
    parameter int SMP_W  = 16;
    parameter int COEF_W = 16;
    parameter int FRAC_W = 14;
    parameter int NTAP   = 8;
    parameter int NBQ    = 5;
    parameter int ACC_W  = 36;
    parameter int IDX_W  = 4;

    localparam int NCOEF = NTAP + NBQ;

    localparam logic signed [ACC_W-1:0] SMP_MAX =
        ACC_W'((64'sd1 <<< (SMP_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SMP_MIN = -SMP_MAX - 1;

    function automatic logic signed [ACC_W-1:0] mul_w(
        input logic signed [SMP_W-1:0]  a,
        input logic signed [COEF_W-1:0] b
    );
        return ACC_W'(a) * ACC_W'(b);
    endfunction

    function automatic logic signed [SMP_W-1:0] clamp_smp(
        input logic signed [ACC_W-1:0] v
    );
        logic signed [ACC_W-1:0] c;
        c = v;
        if (v > SMP_MAX) c = SMP_MAX;
        if (v < SMP_MIN) c = SMP_MIN;
        return SMP_W'(c);
    endfunction

    function automatic logic signed [SMP_W-1:0] scale_clamp(
        input logic signed [ACC_W-1:0] v
    );
        logic signed [ACC_W-1:0] s;
        s = v >>> FRAC_W;
        return clamp_smp(s);
    endfunction
endpackage

// File: rtl/ebf_coef_bank.sv
module ebf_coef_bank
    import ebf_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int LINE_W    = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [LINE_W-1:0]                   wr_line,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [COEF_W-1:0]                   wr_data,
    input  logic [LINE_W-1:0]                   rd_fir_line,
    input  logic [LINE_W-1:0]                   rd_bq_line,
    output logic [NTAP-1:0][COEF_W-1:0]         fir_coef,
    output logic [NBQ-1:0][COEF_W-1:0]          bq_coef,
    output logic [NUM_LINES-1:0]                line_clr
);
    typedef struct packed {
        logic [NUM_LINES-1:0][NCOEF-1:0][COEF_W-1:0] c;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  idx_ok;

    always_comb begin
        bank_d   = bank_q;
        line_clr = '0;
        idx_ok   = (wr_idx < IDX_W'(NCOEF));
        for (int l = 0; l < NUM_LINES; l++) begin
            if (wr_en && idx_ok && (wr_line == LINE_W'(l))) begin
                bank_d.c[l][wr_idx] = wr_data;
                line_clr[l]         = 1'b1;
            end
        end
    end

    always_comb begin
        fir_coef = '0;
        bq_coef  = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (rd_fir_line == LINE_W'(l)) begin
                for (int k = 0; k < NTAP; k++) fir_coef[k] = bank_q.c[l][k];
            end
            if (rd_bq_line == LINE_W'(l)) begin
                for (int j = 0; j < NBQ; j++) bq_coef[j] = bank_q.c[l][NTAP+j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end
endmodule

// File: rtl/ebf_fir_dp.sv
module ebf_fir_dp
    import ebf_pkg::*;
(
    input  logic [NTAP-1:0][SMP_W-1:0]   hist_x,
    input  logic [NTAP-1:0][COEF_W-1:0]  tap_h,
    output logic signed [SMP_W-1:0]      fir_y
);
    logic signed [ACC_W-1:0] prod [NTAP];
    logic signed [ACC_W-1:0] acc;

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign prod[g] = mul_w($signed(hist_x[g]), $signed(tap_h[g]));
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAP; k++) acc = acc + prod[k];
        fir_y = scale_clamp(acc);
    end
endmodule

// File: rtl/ebf_biquad_dp.sv
module ebf_biquad_dp
    import ebf_pkg::*;
(
    input  logic signed [SMP_W-1:0]      f0,
    input  logic signed [SMP_W-1:0]      f1,
    input  logic signed [SMP_W-1:0]      f2,
    input  logic signed [SMP_W-1:0]      y1,
    input  logic signed [SMP_W-1:0]      y2,
    input  logic [NBQ-1:0][COEF_W-1:0]   coef,
    input  logic signed [SMP_W-1:0]      rx,
    output logic signed [SMP_W-1:0]      echo_y,
    output logic signed [SMP_W-1:0]      clean
);
    logic signed [ACC_W-1:0] ff_sum, fb_sum, acc, diff;

    always_comb begin
        ff_sum = mul_w(f0, $signed(coef[0]))
               + mul_w(f1, $signed(coef[1]))
               + mul_w(f2, $signed(coef[2]));
        fb_sum = mul_w(y1, $signed(coef[3]))
               + mul_w(y2, $signed(coef[4]));
        acc    = ff_sum - fb_sum;
        echo_y = scale_clamp(acc);
        diff   = ACC_W'(rx) - ACC_W'(echo_y);
        clean  = clamp_smp(diff);
    end
endmodule

// File: rtl/echo_bal_filter.sv
module echo_bal_filter
    import ebf_pkg::*;
#(
    parameter  int NUM_LINES = 2,
    localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic [LINE_W-1:0]        smp_line,
    input  logic signed [15:0]       tx_smp,
    input  logic signed [15:0]       rx_smp,
    input  logic [NUM_LINES-1:0]     bal_off,
    input  logic                     cfg_we,
    input  logic [LINE_W-1:0]        cfg_line,
    input  logic [3:0]               cfg_idx,
    input  logic [15:0]              cfg_data,
    output logic                     res_vld,
    output logic [LINE_W-1:0]        res_line,
    output logic signed [15:0]       res_smp
);
    typedef struct packed {
        logic [NUM_LINES-1:0][NTAP-1:0][SMP_W-1:0] xh;
        logic [NUM_LINES-1:0][1:0][SMP_W-1:0]      fh;
        logic [NUM_LINES-1:0][1:0][SMP_W-1:0]      yh;
        logic                                      a_vld;
        logic [LINE_W-1:0]                         a_line;
        logic                                      a_off;
        logic [SMP_W-1:0]                          a_f;
        logic [SMP_W-1:0]                          a_rx;
        logic                                      o_vld;
        logic [LINE_W-1:0]                         o_line;
        logic [SMP_W-1:0]                          o_smp;
    } st_t;

    st_t st_d, st_q;

    logic [NTAP-1:0][COEF_W-1:0]  fir_coef;
    logic [NBQ-1:0][COEF_W-1:0]   bq_coef;
    logic [NUM_LINES-1:0]         line_clr;
    logic [NTAP-1:0][SMP_W-1:0]   hist_new;
    logic signed [SMP_W-1:0]      fir_y;
    logic signed [SMP_W-1:0]      f1_sel, f2_sel, y1_sel, y2_sel;
    logic signed [SMP_W-1:0]      echo_y, clean;
    logic                         off_sel;

    ebf_coef_bank #(
        .NUM_LINES (NUM_LINES),
        .LINE_W    (LINE_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_line     (cfg_line),
        .wr_idx      (cfg_idx),
        .wr_data     (cfg_data),
        .rd_fir_line (smp_line),
        .rd_bq_line  (st_q.a_line),
        .fir_coef    (fir_coef),
        .bq_coef     (bq_coef),
        .line_clr    (line_clr)
    );

    // history of the strobed line with the new sample shifted in
    always_comb begin
        hist_new = '0;
        off_sel  = 1'b0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (smp_line == LINE_W'(l)) begin
                off_sel     = bal_off[l];
                hist_new[0] = tx_smp;
                for (int k = 1; k < NTAP; k++) hist_new[k] = st_q.xh[l][k-1];
            end
        end
    end

    ebf_fir_dp u_fir (
        .hist_x (hist_new),
        .tap_h  (fir_coef),
        .fir_y  (fir_y)
    );

    always_comb begin
        f1_sel = '0;
        f2_sel = '0;
        y1_sel = '0;
        y2_sel = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (st_q.a_line == LINE_W'(l)) begin
                f1_sel = st_q.fh[l][0];
                f2_sel = st_q.fh[l][1];
                y1_sel = st_q.yh[l][0];
                y2_sel = st_q.yh[l][1];
            end
        end
    end

    ebf_biquad_dp u_bq (
        .f0     ($signed(st_q.a_f)),
        .f1     (f1_sel),
        .f2     (f2_sel),
        .y1     (y1_sel),
        .y2     (y2_sel),
        .coef   (bq_coef),
        .rx     ($signed(st_q.a_rx)),
        .echo_y (echo_y),
        .clean  (clean)
    );

    always_comb begin
        st_d = st_q;

        // stage A: FIR
        st_d.a_vld = smp_vld;
        if (smp_vld) begin
            st_d.a_line = smp_line;
            st_d.a_off  = off_sel;
            st_d.a_f    = fir_y;
            st_d.a_rx   = rx_smp;
            for (int l = 0; l < NUM_LINES; l++) begin
                if (smp_line == LINE_W'(l) && !off_sel) st_d.xh[l] = hist_new;
            end
        end

        // stage B: biquad and subtraction
        st_d.o_vld = st_q.a_vld;
        if (st_q.a_vld) begin
            st_d.o_line = st_q.a_line;
            if (st_q.a_off) begin
                st_d.o_smp = st_q.a_rx;
            end else begin
                st_d.o_smp = clean;
                for (int l = 0; l < NUM_LINES; l++) begin
                    if (st_q.a_line == LINE_W'(l)) begin
                        st_d.fh[l][1] = st_q.fh[l][0];
                        st_d.fh[l][0] = st_q.a_f;
                        st_d.yh[l][1] = st_q.yh[l][0];
                        st_d.yh[l][0] = echo_y;
                    end
                end
            end
        end

        // reconfiguration empties the history
        for (int l = 0; l < NUM_LINES; l++) begin
            if (bal_off[l] || line_clr[l]) begin
                st_d.xh[l] = '0;
                st_d.fh[l] = '0;
                st_d.yh[l] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_vld  = st_q.o_vld;
    assign res_line = st_q.o_line;
    assign res_smp  = $signed(st_q.o_smp);
endmodule

// File: rtl/echo_bal_filter_chk.sv
module echo_bal_filter_chk #(
    parameter int NUM_LINES = 2,
    parameter int LINE_W    = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 smp_vld,
    input logic [LINE_W-1:0]    smp_line,
    input logic signed [15:0]   rx_smp,
    input logic [NUM_LINES-1:0] bal_off,
    input logic                 res_vld,
    input logic [LINE_W-1:0]    res_line,
    input logic signed [15:0]   res_smp
);
    // R1: result valid low in the cycle after reset is held
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !res_vld);

    // R2: every strobe gives a result two edges later
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> ##1 res_vld);

    // R2: no result without a strobe
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ##1 !res_vld);

    // R11: results keep their line tag in order
    assert_line_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> ##1 (res_line == $past(smp_line, 2)));

    // R8: disabled line passes received sample unchanged
    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && bal_off[smp_line]) |=> ##1 (res_smp == $past(rx_smp, 2)));
endmodule

bind echo_bal_filter echo_bal_filter_chk #(
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .smp_line (smp_line),
    .rx_smp   (rx_smp),
    .bal_off  (bal_off),
    .res_vld  (res_vld),
    .res_line (res_line),
    .res_smp  (res_smp)
);

// File: tb/sim_echo_bal_filter.sv
`timescale 1ns/1ps
module sim_echo_bal_filter;
    localparam int NL = 3;
    localparam int LW = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_vld = 1'b0;
    logic [LW-1:0]      smp_line = '0;
    logic signed [15:0] tx_smp = '0;
    logic signed [15:0] rx_smp = '0;
    logic [NL-1:0]      bal_off = '0;
    logic               cfg_we = 1'b0;
    logic [LW-1:0]      cfg_line = '0;
    logic [3:0]         cfg_idx = '0;
    logic [15:0]        cfg_data = '0;
    logic               res_vld;
    logic [LW-1:0]      res_line;
    logic signed [15:0] res_smp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    echo_bal_filter #(.NUM_LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_line(smp_line),
        .tx_smp(tx_smp), .rx_smp(rx_smp), .bal_off(bal_off),
        .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .res_vld(res_vld), .res_line(res_line), .res_smp(res_smp)
    );

    // reference model state
    int mc [NL][13];
    int mx [NL][8];
    int mf1[NL], mf2[NL], my1[NL], my2[NL];
    bit moff[NL];

    int bl[64], btx[64], brx[64], bexp[64];
    int bn = 0;

    function automatic int sat16(longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic void clr_model(int l);
        for (int k = 0; k < 8; k++) mx[l][k] = 0;
        mf1[l] = 0; mf2[l] = 0; my1[l] = 0; my2[l] = 0;
    endfunction

    function automatic int model_step(int l, int tx, int rx);
        longint acc;
        int f, y;
        if (moff[l]) return rx;
        for (int k = 7; k > 0; k--) mx[l][k] = mx[l][k-1];
        mx[l][0] = tx;
        acc = 0;
        for (int k = 0; k < 8; k++) acc += longint'(mc[l][k]) * longint'(mx[l][k]);
        f = sat16(acc >>> 14);
        acc = longint'(mc[l][8]) * f + longint'(mc[l][9]) * mf1[l]
            + longint'(mc[l][10]) * mf2[l]
            - longint'(mc[l][11]) * my1[l] - longint'(mc[l][12]) * my2[l];
        y = sat16(acc >>> 14);
        mf2[l] = mf1[l]; mf1[l] = f;
        my2[l] = my1[l]; my1[l] = y;
        return sat16(longint'(rx) - y);
    endfunction

    function automatic int rnd16();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_coef(int l, int idx, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_line = LW'(l); cfg_idx = 4'(idx); cfg_data = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 13) begin
            mc[l][idx] = sat16(val);
            clr_model(l);
        end
    endtask

    task automatic set_off(int l, bit v);
        @(negedge clk);
        bal_off[l] = v;
        moff[l] = v;
        if (v) clr_model(l);
    endtask

    task automatic add(int l, int tx, int rx);
        bl[bn] = l; btx[bn] = tx; brx[bn] = rx; bn++;
    endtask

    // back-to-back burst, results checked two cycles after each strobe
    task automatic run(string req);
        for (int i = 0; i <= bn + 1; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk({req, " R2 vld"}, int'(res_vld), 1);
                chk({req, " R11 line"}, int'(res_line), bl[i-2]);
                chk(req, int'(res_smp), bexp[i-2]);
            end
            if (i < bn) begin
                smp_vld = 1'b1; smp_line = LW'(bl[i]);
                tx_smp = 16'(btx[i]); rx_smp = 16'(brx[i]);
                bexp[i] = model_step(bl[i], btx[i], brx[i]);
            end else begin
                smp_vld = 1'b0;
            end
        end
        @(negedge clk);
        chk("R2 idle", int'(res_vld), 0);
        bn = 0;
    endtask

    task automatic rand_coefs(int l, int fb_mag);
        for (int k = 0; k < 11; k++) wr_coef(l, k, rnd16() / 4);
        wr_coef(l, 11, int'($urandom_range(0, 2 * fb_mag)) - fb_mag);
        wr_coef(l, 12, int'($urandom_range(0, 2 * fb_mag)) - fb_mag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd51723));
        for (int l = 0; l < NL; l++) begin
            moff[l] = 0;
            clr_model(l);
            for (int k = 0; k < 13; k++) mc[l][k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset vld", int'(res_vld), 0);

        // R1: zero coefficients pass rx through
        add(0, 1234, -777); add(2, -32768, 32767); add(1, 500, 0);
        run("R1 zero coef");

        // R3: FIR impulse response with unity b0
        for (int k = 0; k < 8; k++) wr_coef(0, k, (k + 1) * 1000 - 4000);
        wr_coef(0, 8, 16384);
        add(0, 8000, 100);
        for (int i = 0; i < 9; i++) add(0, 0, 100);
        run("R3 impulse");

        // R4: biquad with feedback on line 1
        wr_coef(1, 0, 16384);
        wr_coef(1, 8, 8000); wr_coef(1, 9, 4000); wr_coef(1, 10, -3000);
        wr_coef(1, 11, -9000); wr_coef(1, 12, 4000);
        add(1, 10000, 0);
        for (int i = 0; i < 10; i++) add(1, 0, 0);
        run("R4 biquad");

        // R5, R7, R11: random coefficients, interleaved lines
        rand_coefs(0, 6000);
        rand_coefs(1, 6000);
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 40; i++) add(int'($urandom_range(0, 1)), rnd16(), rnd16());
            run("R5 R7 random");
        end
        // R7: idle line 2 still has zero coefficients
        add(2, 3000, 2222);
        run("R7 idle line");

        // R6: clamping at both ends
        for (int l = 0; l < 1; l++) begin
            wr_coef(2, 0, 32767);
            wr_coef(2, 8, 16384);
        end
        add(2, 32767, -32768);
        add(2, -32768, 32767);
        add(2, 0, 0);
        run("R6 saturate");

        // R8: disable bypass then restart
        add(0, 5000, 300); add(0, -4000, 200);
        run("R8 pre");
        set_off(0, 1'b1);
        add(0, 7000, -1500); add(1, 1111, 2222); add(0, -7000, 1600);
        run("R8 off");
        set_off(0, 1'b0);
        add(0, 9000, 10); add(0, 0, 20); add(0, 0, 30);
        run("R8 restart");

        // R9: coefficient write clears history of that line only
        add(1, 20000, 0); add(0, 20000, 0); add(1, -15000, 5); add(0, 15000, 7);
        run("R9 fill");
        wr_coef(1, 3, 2000);
        add(1, 0, 0); add(0, 0, 0); add(1, 0, 0); add(0, 0, 0);
        run("R9 after write");

        // R10: writes to unused indices are ignored
        add(0, 12000, 50); add(0, -9000, 60);
        run("R10 fill");
        wr_coef(0, 13, 16384);
        wr_coef(0, 14, -1);
        wr_coef(0, 15, 32767);
        add(0, 0, 70); add(0, 0, 80); add(0, 0, 90);
        run("R10 unused idx");

        // mixed random including all three lines and disables
        rand_coefs(2, 12000);
        for (int r = 0; r < 4; r++) begin
            set_off(1, bit'(r[0]));
            for (int i = 0; i < 30; i++) add(int'($urandom_range(0, 2)), rnd16(), rnd16());
            run("R5 R8 mixed");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule